// File: doc/BRIEF.md
# Multithreaded Pipeline Stage Controller

This block manages one stage of an in-order pipeline that is shared by several hardware threads. Each cycle the previous stage may present up to `LANES` entries. Each entry carries a tag, a thread number and a sequence number. Accepted entries go into a small per-thread skid buffer and are forwarded on the next cycles. Forwarding follows each thread's buffer order, serves threads in ascending index, and is limited by the lane count and by the free slots that the next stage reports.

Every thread has its own five-state status: Idle, Running, Blocked, Unblocking or Squashing. When the thread is stalled, it drives one-cycle block and unblock pulses back to the previous stage. A squash request for a thread carries a sequence number. It removes that thread's buffered and arriving entries that are younger than that number and keeps the older ones. A per-thread "head done" input stands in for the completion of the head entry's work in this stage. The block reports its own remaining buffer space upstream as a combinational count.

Top module: `mt_stage_ctl`

## Requirements
- R1: While reset is asserted, and until the first clock after its release, every thread status reads Idle (code 0), no output lane is valid, no pulse is high, and `up_free` equals `CAPACITY` when no input is valid.
- R2: An incoming entry with its kill flag set is never stored and is never forwarded.
- R3: An entry accepted in cycle n can leave at the earliest in cycle n+1. Output lanes are filled from lane 0 with no gaps, in thread-index order and, within a thread, in the thread's acceptance order. At most `min(LANES, dn_free)` entries leave per cycle, and outputs are registered.
- R4: A thread whose `head_done` bit is low forwards nothing in that cycle.
- R5: A squash request for thread t with number S removes t's buffered entries whose sequence number is above S, keeps those at or below S, and drops t's arriving entries above S. The thread then reads Squashing (code 4). On the next non-squash, non-stall evaluation it forwards as Unblocking (code 3) if its buffer is non-empty, and as Running (code 1) if it is empty.
- R6: A stalled thread reads Blocked (code 2) and forwards nothing. Its block pulse is high for exactly one cycle, and only when the thread was not already Blocked.
- R7: A Blocked thread that is no longer stalled evaluates as Unblocking. It becomes Running and raises a one-cycle unblock pulse in the cycle its buffer drains to empty. Until then it stays Unblocking.
- R8: An Idle or Running thread that still holds entries after forwarding becomes Blocked, with no block pulse. An Idle thread becomes Running once it forwards an entry.
- R9: `up_free` equals `CAPACITY` minus the entries held in all skid buffers minus the count of valid input lanes this cycle. A thread's buffer never exceeds `DEPTH`.
- R10: A squash takes priority over a stall in the same cycle, and a stall takes priority over forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | LANES | Incoming lane valid |
| in_kill | input | LANES | Incoming lane already squashed |
| in_tag | input | LANES*TAG_W | Incoming tags |
| in_tid | input | LANES*TID_W | Incoming thread numbers |
| in_seq | input | LANES*SEQ_W | Incoming sequence numbers |
| sq_req | input | NUM_THR | Squash request per thread |
| sq_seq | input | NUM_THR*SEQ_W | Squash boundary per thread |
| stall | input | NUM_THR | Stall from later stages per thread |
| head_done | input | NUM_THR | Head entry finished its work here |
| dn_free | input | FREE_W | Free slots in the next stage |
| out_vld | output | LANES | Outgoing lane valid |
| out_tag | output | LANES*TAG_W | Outgoing tags |
| out_tid | output | LANES*TID_W | Outgoing thread numbers |
| out_seq | output | LANES*SEQ_W | Outgoing sequence numbers |
| blk_pulse | output | NUM_THR | Block pulse to previous stage |
| unblk_pulse | output | NUM_THR | Unblock pulse to previous stage |
| thr_state | output | NUM_THR*3 | Thread status codes |
| up_free | output | FREE_W | Free space offered upstream |

## Verification
A directed prologue first sends a killed entry alone, which tests dropping against storing. It then fills one thread while no downstream credit is available and squashes at a boundary in the middle of the buffered run. This separates tail removal from head removal, and it shows the drain path that follows a squash. After that, a long random phase mixes lane occupancy, credit counts from zero upward, head-done gaps, stalls and squashes on both threads. Credit splitting between threads and the choice between pulse and no pulse on each transition are compared every cycle against a queue-based model.

// File: rtl/pstg_pkg.sv
package pstg_pkg;
  typedef enum logic [2:0] {
    THR_IDLE       = 3'd0,
    THR_RUN        = 3'd1,
    THR_BLOCKED    = 3'd2,
    THR_UNBLOCKING = 3'd3,
    THR_SQUASHING  = 3'd4
  } thr_state_e;
endpackage

// File: rtl/pstg_skid.sv
// Per-thread skid buffer: head at slot 0, shift on pop, tail truncate on squash.
module pstg_skid #(
  parameter int DEPTH  = 4,
  parameter int LANES  = 2,
  parameter int TAG_W  = 8,
  parameter int SEQ_W  = 16,
  parameter int TID_W  = 1,
  parameter int THR_ID = 0,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         acc_vld,
  input  logic [LANES*TAG_W-1:0]   in_tag,
  input  logic [LANES*TID_W-1:0]   in_tid,
  input  logic [LANES*SEQ_W-1:0]   in_seq,
  input  logic [CNT_W-1:0]         pop_n,
  input  logic                     sq_en,
  input  logic [SEQ_W-1:0]         sq_seq,
  output logic [CNT_W-1:0]         cnt,
  output logic [DEPTH*TAG_W-1:0]   hd_tag,
  output logic [DEPTH*SEQ_W-1:0]   hd_seq
);
  logic [TAG_W-1:0] mem_tag [DEPTH];
  logic [SEQ_W-1:0] mem_seq [DEPTH];
  logic [TAG_W-1:0] nt_tag  [DEPTH];
  logic [SEQ_W-1:0] nt_seq  [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd, over;

  always_comb begin
    int keep;
    int base;
    int wp;
    int src;
    logic any_push;
    keep = 0;
    for (int i = 0; i < DEPTH; i++)
      if (i < int'(cnt_q) && mem_seq[i] <= sq_seq) keep++;
    base = sq_en ? keep : int'(cnt_q) - int'(pop_n);
    for (int i = 0; i < DEPTH; i++) begin
      src       = sq_en ? i : i + int'(pop_n);
      nt_tag[i] = mem_tag[i];
      nt_seq[i] = mem_seq[i];
      for (int k = 0; k < DEPTH; k++)
        if (k == src) begin
          nt_tag[i] = mem_tag[k];
          nt_seq[i] = mem_seq[k];
        end
    end
    wp       = base;
    any_push = 1'b0;
    for (int l = 0; l < LANES; l++)
      if (acc_vld[l] && in_tid[l*TID_W +: TID_W] == TID_W'(THR_ID)) begin
        for (int p = 0; p < DEPTH; p++)
          if (p == wp) begin
            nt_tag[p] = in_tag[l*TAG_W +: TAG_W];
            nt_seq[p] = in_seq[l*SEQ_W +: SEQ_W];
          end
        wp++;
        any_push = 1'b1;
      end
    over  = (wp > DEPTH);
    cnt_d = CNT_W'(wp);
    upd   = sq_en || (pop_n != '0) || any_push;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_tag[i] <= nt_tag[i];
        mem_seq[i] <= nt_seq[i];
      end
    end
  end

  assign cnt = cnt_q;
  for (genvar g = 0; g < DEPTH; g++) begin : g_head
    assign hd_tag[g*TAG_W +: TAG_W] = mem_tag[g];
    assign hd_seq[g*SEQ_W +: SEQ_W] = mem_seq[g];
  end

  AST_SKID_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) !over) else $error("skid overflow"); // R9
endmodule

// File: rtl/pstg_thr_ctl.sv
// Per-thread status machine with upstream block/unblock pulses.
module pstg_thr_ctl
  import pstg_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sq_req,
  input  logic             stall,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] fwd_n,
  output logic             can_fwd,
  output thr_state_e       state,
  output logic             blk_p,
  output logic             unblk_p
);
  thr_state_e       st_q, st_d, eff;
  logic             blk_q, blk_d, unblk_q, unblk_d;
  logic [CNT_W-1:0] rem;

  always_comb begin
    eff = st_q;
    if (st_q == THR_BLOCKED)        eff = THR_UNBLOCKING;
    else if (st_q == THR_SQUASHING) eff = (cnt != '0) ? THR_UNBLOCKING : THR_RUN;
    can_fwd = !sq_req && !stall;
    rem     = cnt - fwd_n;
    st_d    = st_q;
    blk_d   = 1'b0;
    unblk_d = 1'b0;
    if (sq_req) begin
      st_d = THR_SQUASHING;
    end else if (stall) begin
      st_d  = THR_BLOCKED;
      blk_d = (st_q != THR_BLOCKED);
    end else if (eff == THR_UNBLOCKING) begin
      if (rem == '0) begin
        st_d    = THR_RUN;
        unblk_d = 1'b1;
      end else begin
        st_d = THR_UNBLOCKING;
      end
    end else if (rem != '0) begin
      st_d = THR_BLOCKED;
    end else if (eff == THR_IDLE && fwd_n == '0) begin
      st_d = THR_IDLE;
    end else begin
      st_d = THR_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= THR_IDLE;
      blk_q   <= 1'b0;
      unblk_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      blk_q   <= blk_d;
      unblk_q <= unblk_d;
    end
  end

  assign state   = st_q;
  assign blk_p   = blk_q;
  assign unblk_p = unblk_q;

  AST_BLK_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) blk_q |=> !blk_q) else $error("block pulse too wide"); // R6
  AST_UNBLK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) unblk_q |=> !unblk_q) else $error("unblock pulse too wide"); // R7
  AST_SQUASH_ENTRY:    assert property (@(posedge clk) disable iff (!rst_n) sq_req |=> st_q == THR_SQUASHING) else $error("squash not taken"); // R5
  AST_STALL_NO_FWD:    assert property (@(posedge clk) disable iff (!rst_n) (stall || sq_req) |-> fwd_n == '0) else $error("forward while held"); // R10
endmodule

// File: rtl/mt_stage_ctl.sv
module mt_stage_ctl
  import pstg_pkg::*;
#(
  parameter int NUM_THR  = 2,
  parameter int LANES    = 2,
  parameter int DEPTH    = 4,
  parameter int CAPACITY = 8,
  parameter int TAG_W    = 8,
  parameter int SEQ_W    = 16,
  localparam int TID_W   = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int FREE_W  = $clog2(CAPACITY + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LANES-1:0]       in_vld,
  input  logic [LANES-1:0]       in_kill,
  input  logic [LANES*TAG_W-1:0] in_tag,
  input  logic [LANES*TID_W-1:0] in_tid,
  input  logic [LANES*SEQ_W-1:0] in_seq,
  input  logic [NUM_THR-1:0]     sq_req,
  input  logic [NUM_THR*SEQ_W-1:0] sq_seq,
  input  logic [NUM_THR-1:0]     stall,
  input  logic [NUM_THR-1:0]     head_done,
  input  logic [FREE_W-1:0]      dn_free,
  output logic [LANES-1:0]       out_vld,
  output logic [LANES*TAG_W-1:0] out_tag,
  output logic [LANES*TID_W-1:0] out_tid,
  output logic [LANES*SEQ_W-1:0] out_seq,
  output logic [NUM_THR-1:0]     blk_pulse,
  output logic [NUM_THR-1:0]     unblk_pulse,
  output logic [NUM_THR*3-1:0]   thr_state,
  output logic [FREE_W-1:0]      up_free
);
  logic [LANES-1:0]       acc;
  logic [CNT_W-1:0]       cnt     [NUM_THR];
  logic [CNT_W-1:0]       fwd_n   [NUM_THR];
  logic [DEPTH*TAG_W-1:0] hd_tag  [NUM_THR];
  logic [DEPTH*SEQ_W-1:0] hd_seq  [NUM_THR];
  logic [NUM_THR-1:0]     can_fwd;
  logic [LANES-1:0]       o_vld_d, o_vld_q;
  logic [LANES*TAG_W-1:0] o_tag_d, o_tag_q;
  logic [LANES*TID_W-1:0] o_tid_d, o_tid_q;
  logic [LANES*SEQ_W-1:0] o_seq_d, o_seq_q;
  logic                   cap_over;

  // Incoming filter: killed lanes and lanes younger than a same-cycle squash.
  always_comb begin
    logic [TID_W-1:0] tl;
    logic hit;
    for (int l = 0; l < LANES; l++) begin
      tl  = in_tid[l*TID_W +: TID_W];
      hit = 1'b0;
      for (int t = 0; t < NUM_THR; t++)
        if (tl == TID_W'(t) && sq_req[t] &&
            in_seq[l*SEQ_W +: SEQ_W] > sq_seq[t*SEQ_W +: SEQ_W]) hit = 1'b1;
      acc[l] = in_vld[l] && !in_kill[l] && !hit;
    end
  end

  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    thr_state_e st;
    pstg_skid #(
      .DEPTH(DEPTH), .LANES(LANES), .TAG_W(TAG_W), .SEQ_W(SEQ_W),
      .TID_W(TID_W), .THR_ID(t)
    ) u_skid (
      .clk(clk), .rst_n(rst_n), .acc_vld(acc), .in_tag(in_tag),
      .in_tid(in_tid), .in_seq(in_seq), .pop_n(fwd_n[t]),
      .sq_en(sq_req[t]), .sq_seq(sq_seq[t*SEQ_W +: SEQ_W]),
      .cnt(cnt[t]), .hd_tag(hd_tag[t]), .hd_seq(hd_seq[t])
    );
    pstg_thr_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .sq_req(sq_req[t]), .stall(stall[t]),
      .cnt(cnt[t]), .fwd_n(fwd_n[t]), .can_fwd(can_fwd[t]), .state(st),
      .blk_p(blk_pulse[t]), .unblk_p(unblk_pulse[t])
    );
    assign thr_state[t*3 +: 3] = st;
  end

  // Credit split: lowest thread index first, lanes packed from lane 0.
  always_comb begin
    int budget;
    int lane;
    int n;
    budget  = (int'(dn_free) < LANES) ? int'(dn_free) : LANES;
    lane    = 0;
    o_vld_d = '0;
    o_tag_d = '0;
    o_tid_d = '0;
    o_seq_d = '0;
    for (int t = 0; t < NUM_THR; t++) begin
      n = 0;
      if (can_fwd[t] && head_done[t])
        n = (int'(cnt[t]) < budget) ? int'(cnt[t]) : budget;
      fwd_n[t] = CNT_W'(n);
      budget   = budget - n;
      for (int j = 0; j < DEPTH; j++)
        if (j < n && lane < LANES) begin
          o_vld_d[lane]                  = 1'b1;
          o_tag_d[lane*TAG_W +: TAG_W]   = hd_tag[t][j*TAG_W +: TAG_W];
          o_seq_d[lane*SEQ_W +: SEQ_W]   = hd_seq[t][j*SEQ_W +: SEQ_W];
          o_tid_d[lane*TID_W +: TID_W]   = TID_W'(t);
          lane++;
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) o_vld_q <= '0;
    else        o_vld_q <= o_vld_d;
  end

  always_ff @(posedge clk) begin
    if (|o_vld_d) begin
      o_tag_q <= o_tag_d;
      o_tid_q <= o_tid_d;
      o_seq_q <= o_seq_d;
    end
  end

  assign out_vld = o_vld_q;
  assign out_tag = o_tag_q;
  assign out_tid = o_tid_q;
  assign out_seq = o_seq_q;

  // Space offered upstream across all threads.
  always_comb begin
    int used;
    used = 0;
    for (int t = 0; t < NUM_THR; t++) used += int'(cnt[t]);
    for (int l = 0; l < LANES; l++)   used += int'(in_vld[l]);
    cap_over = (used > CAPACITY);
    up_free  = cap_over ? '0 : FREE_W'(CAPACITY - used);
  end

  AST_SHARED_CAP:   assert property (@(posedge clk) disable iff (!rst_n) !cap_over) else $error("shared capacity exceeded"); // R9
  AST_LANES_PACKED: assert property (@(posedge clk) disable iff (!rst_n) ((o_vld_q + 1'b1) & o_vld_q) == '0) else $error("lane gap"); // R3
  AST_CREDIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) $countones(o_vld_d) <= int'(dn_free)) else $error("credit overrun"); // R3
endmodule

// File: tb/mt_stage_ctl_bench.sv
module mt_stage_ctl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 2, LN = 2, DP = 4, CAP = 8, TW = 8, SW = 16;
  localparam int IW = 1, FW = 4;

  logic clk, rst_n;
  logic [LN-1:0] in_vld, in_kill;
  logic [LN*TW-1:0] in_tag;
  logic [LN*IW-1:0] in_tid;
  logic [LN*SW-1:0] in_seq;
  logic [NT-1:0] sq_req, stall, head_done;
  logic [NT*SW-1:0] sq_seq;
  logic [FW-1:0] dn_free;
  logic [LN-1:0] out_vld;
  logic [LN*TW-1:0] out_tag;
  logic [LN*IW-1:0] out_tid;
  logic [LN*SW-1:0] out_seq;
  logic [NT-1:0] blk_pulse, unblk_pulse;
  logic [NT*3-1:0] thr_state;
  logic [FW-1:0] up_free;

  mt_stage_ctl u_mt_stage_ctl (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_kill(in_kill), .in_tag(in_tag),
    .in_tid(in_tid), .in_seq(in_seq), .sq_req(sq_req), .sq_seq(sq_seq), .stall(stall),
    .head_done(head_done), .dn_free(dn_free), .out_vld(out_vld), .out_tag(out_tag),
    .out_tid(out_tid), .out_seq(out_seq), .blk_pulse(blk_pulse), .unblk_pulse(unblk_pulse),
    .thr_state(thr_state), .up_free(up_free)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: one queue per thread, entries packed as {tag, seq}.
  logic [TW+SW-1:0] mq [NT][$];
  int mst [NT];
  int exp_vld [LN], exp_tag [LN], exp_tid [LN], exp_seq [LN];
  int exp_blk [NT], exp_unblk [NT];
  int nseq [NT];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int expv);
    n_cmp++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic clear_inputs();
    in_vld = '0; in_kill = '0; in_tag = '0; in_tid = '0; in_seq = '0;
    sq_req = '0; sq_seq = '0; stall = '0; head_done = '1; dn_free = '0;
  endtask

  task automatic put_lane(int l, int t, int seq, int tag, bit kill);
    in_vld[l] = 1'b1; in_kill[l] = kill;
    in_tid[l*IW +: IW] = IW'(t); in_seq[l*SW +: SW] = SW'(seq); in_tag[l*TW +: TW] = TW'(tag);
  endtask

  task automatic model_eval();
    int budget, lane, sz, n, rem, eff, sq;
    logic [TW+SW-1:0] e;
    budget = (int'(dn_free) < LN) ? int'(dn_free) : LN;
    lane = 0;
    for (int l = 0; l < LN; l++) exp_vld[l] = 0;
    for (int t = 0; t < NT; t++) begin
      exp_blk[t] = 0; exp_unblk[t] = 0;
      sz = mq[t].size();
      if (sq_req[t]) begin
        sq = int'(sq_seq[t*SW +: SW]);
        while (mq[t].size() > 0 && int'(mq[t][$][SW-1:0]) > sq) void'(mq[t].pop_back());
        mst[t] = 4;
      end else if (stall[t]) begin
        if (mst[t] != 2) exp_blk[t] = 1;
        mst[t] = 2;
      end else begin
        eff = mst[t];
        if (eff == 2) eff = 3;
        else if (eff == 4) eff = (sz != 0) ? 3 : 1;
        n = 0;
        if (head_done[t]) n = (sz < budget) ? sz : budget;
        for (int j = 0; j < n; j++) begin
          e = mq[t].pop_front();
          exp_vld[lane] = 1; exp_tid[lane] = t;
          exp_tag[lane] = int'(e[TW+SW-1:SW]); exp_seq[lane] = int'(e[SW-1:0]);
          lane++;
        end
        budget -= n;
        rem = sz - n;
        if (eff == 3) begin
          if (rem == 0) begin mst[t] = 1; exp_unblk[t] = 1; end
          else mst[t] = 3;
        end else if (rem != 0) mst[t] = 2;
        else if (eff == 0 && n == 0) mst[t] = 0;
        else mst[t] = 1;
      end
    end
    for (int l = 0; l < LN; l++) begin
      int t;
      t = int'(in_tid[l*IW +: IW]);
      if (in_vld[l] && !in_kill[l] &&
          !(sq_req[t] && in_seq[l*SW +: SW] > sq_seq[t*SW +: SW]))
        mq[t].push_back({in_tag[l*TW +: TW], in_seq[l*SW +: SW]});
    end
  endtask

  task automatic compare_regs();
    for (int l = 0; l < LN; l++) begin
      chk("R3/R4", $sformatf("lane%0d valid", l), int'(out_vld[l]), exp_vld[l]);
      if (exp_vld[l] != 0 && out_vld[l]) begin
        chk("R3", $sformatf("lane%0d tid", l), int'(out_tid[l*IW +: IW]), exp_tid[l]);
        chk("R3", $sformatf("lane%0d seq", l), int'(out_seq[l*SW +: SW]), exp_seq[l]);
        chk("R3", $sformatf("lane%0d tag", l), int'(out_tag[l*TW +: TW]), exp_tag[l]);
      end
    end
    for (int t = 0; t < NT; t++) begin
      chk("R6/R10", $sformatf("blk%0d", t), int'(blk_pulse[t]), exp_blk[t]);
      chk("R7", $sformatf("unblk%0d", t), int'(unblk_pulse[t]), exp_unblk[t]);
      chk("R5/R8/R10", $sformatf("state%0d", t), int'(thr_state[t*3 +: 3]), mst[t]);
    end
  endtask

  // Inputs are already driven (after a negedge); check space, model, advance.
  task automatic step();
    int used;
    #1;
    used = 0;
    for (int t = 0; t < NT; t++) used += mq[t].size();
    for (int l = 0; l < LN; l++) used += int'(in_vld[l]);
    chk("R9", "up_free", int'(up_free), CAP - used);
    model_eval();
    @(negedge clk);
    compare_regs();
  endtask

  task automatic gen_random();
    int pend [NT];
    clear_inputs();
    for (int t = 0; t < NT; t++) pend[t] = mq[t].size();
    for (int l = 0; l < LN; l++) begin
      int t;
      t = $urandom % NT;
      if (($urandom % 3) != 0 && pend[t] < DP) begin
        put_lane(l, t, nseq[t], $urandom % 256, ($urandom % 8) == 0);
        nseq[t]++; pend[t]++;
      end
    end
    for (int t = 0; t < NT; t++) begin
      int s;
      sq_req[t] = ($urandom % 14) == 0;
      s = nseq[t] - 1 - int'($urandom % 4);
      if (s < 0) s = 0;
      sq_seq[t*SW +: SW] = SW'(s);
      stall[t] = ($urandom % 6) == 0;
      head_done[t] = ($urandom % 5) != 0;
    end
    dn_free = FW'($urandom % 4);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int t = 0; t < NT; t++) begin mst[t] = 0; nseq[t] = 1; end
    clear_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "out_vld", int'(out_vld), 0);
    chk("R1", "thr_state", int'(thr_state), 0);
    chk("R1", "blk_pulse", int'(blk_pulse), 0);
    chk("R1", "unblk_pulse", int'(unblk_pulse), 0);
    chk("R1", "up_free", int'(up_free), CAP);
    rst_n = 1'b1;
    for (int l = 0; l < LN; l++) exp_vld[l] = 0;
    for (int t = 0; t < NT; t++) begin exp_blk[t] = 0; exp_unblk[t] = 0; end

    // R2: killed entry alone is dropped.
    clear_inputs(); dn_free = 4'd2;
    put_lane(0, 0, 100, 8'h5a, 1'b1);
    step();
    clear_inputs(); dn_free = 4'd2;
    step();
    chk("R2", "out_vld after kill", int'(out_vld), 0);
    chk("R2", "up_free after kill", int'(up_free), CAP);

    // R5/R8: fill thread 0 with no credit, squash mid-run, then drain.
    clear_inputs();
    put_lane(0, 0, 1, 8'h11, 1'b0); put_lane(1, 0, 2, 8'h22, 1'b0);
    step();
    clear_inputs();
    put_lane(0, 0, 3, 8'h33, 1'b0);
    step();
    chk("R8", "state0 blocked", int'(thr_state[2:0]), 2);
    chk("R8", "no block pulse", int'(blk_pulse[0]), 0);
    clear_inputs();
    sq_req[0] = 1'b1; sq_seq[SW-1:0] = SW'(2);
    step();
    chk("R5", "state0 squashing", int'(thr_state[2:0]), 4);
    clear_inputs(); dn_free = 4'd2;
    step();
    chk("R5", "kept seq lane0", int'(out_seq[SW-1:0]), 1);
    chk("R5", "kept seq lane1", int'(out_seq[2*SW-1:SW]), 2);
    chk("R7", "unblock after drain", int'(unblk_pulse[0]), 1);
    clear_inputs(); dn_free = 4'd2;
    step();
    chk("R5", "younger entry gone", int'(out_vld), 0);
    for (int t = 0; t < NT; t++) nseq[t] = 10;

    // Random phase: R3 R4 R6 R7 R9 R10 compared every cycle.
    for (int i = 0; i < 4000; i++) begin
      gen_random();
      step();
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule